// File: doc/BRIEF.md
# Core Execution Mode Switch Controller

This controller sits beside a core that can run either as an out-of-order machine for a few threads or as a heavily threaded in-order machine. It watches how many hardware threads are active and picks the mode: out-of-order while the count is at or below a small limit, in-order above it. A requested change must hold for a programmable number of cycles before anything happens, so a thread count that flickers across the limit does not cause repeated switches.

Once a switch is committed, the controller steps through four phases in a fixed order. First it empties the pipeline. Next it has the active threads' architectural registers saved. Then it turns the renaming, out-of-order scheduling and load-queue units on or off. Last it has the registers of the next thread set loaded back. The save and load engines are outside the block and are seen only as start pulses and done inputs. Instruction fetch is held from the first phase until the last one ends. While a switch is in progress, the controller does not look at the thread count.

Top module: `mode_switch_ctrl`

## Requirements
- R1: The target mode is out-of-order when `active_threads` ≤ OOO_MAX (default 2) and in-order otherwise. `mode_ooo` reads 1 for out-of-order and 0 for in-order.
- R2: A switch starts only after the thread count has asked for the other mode on `hold_cycles`+1 consecutive rising edges while idle. One edge that asks for the current mode restarts that count from zero. `drain_req` rises one cycle after the qualifying edge.
- R3: `drain_req` stays high from the start of the switch until a rising edge that sees `pipe_empty` high. It is high only during this phase.
- R4: `spill_start` is a one-cycle pulse in the first cycle after the drain ends. The controller then waits for `spill_done`.
- R5: One cycle after `spill_done` is seen, the mode flips. `rename_en`, `ooo_sched_en` and `ldq_en` then all equal `mode_ooo`, so they are all 1 in out-of-order mode and all 0 in in-order mode.
- R6: `fill_start` pulses for one cycle right after the mode flips. `rat_update` pulses in that same cycle only when the new mode is out-of-order.
- R7: `fetch_stall` is high from the first drain cycle through the cycle in which `fill_done` is sampled, and low whenever the controller is idle.
- R8: A change in `active_threads` during a switch has no effect on the phases. After the switch returns to idle, the hold count starts again from zero.
- R9: `pipe_empty`, `spill_done` and `fill_done` have no effect outside the phase that waits for them.
- R10: During and right after reset, the mode is out-of-order, all three unit enables are 1, and `drain_req`, `spill_start`, `fill_start`, `rat_update` and `fetch_stall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_threads | input | CNT_W | Number of active hardware threads |
| hold_cycles | input | HOLD_W | Extra edges a mode change request must persist |
| pipe_empty | input | 1 | Pipeline holds no instructions |
| spill_done | input | 1 | Register save engine finished |
| fill_done | input | 1 | Register load engine finished |
| drain_req | output | 1 | Request to empty the pipeline |
| spill_start | output | 1 | One-cycle start pulse to the register save engine |
| fill_start | output | 1 | One-cycle start pulse to the register load engine |
| rat_update | output | 1 | Map-table rebuild strobe during the load step |
| rename_en | output | 1 | Register renaming enable |
| ooo_sched_en | output | 1 | Out-of-order scheduler enable |
| ldq_en | output | 1 | Load queue enable |
| mode_ooo | output | 1 | Current mode, 1 = out-of-order |
| fetch_stall | output | 1 | Hold instruction fetch |

## Verification
If the hold counter is wrong, `drain_req` rises one or more cycles too early or too late compared with a thread-count trace. This shows at the ports in the first switch after the fault. If the phase register is wrong, a start pulse goes missing or is repeated, or `fetch_stall` disagrees with `drain_req`, within one cycle of the faulty transition. If the mode register is wrong, `mode_ooo`, the three enables and `rat_update` disagree with the direction of the switch in the cycle right after the reconfigure phase.

// File: rtl/msw_pkg.sv
package msw_pkg;
  typedef enum logic [2:0] {
    PH_RUN    = 3'd0,
    PH_DRAIN  = 3'd1,
    PH_SPILL  = 3'd2,
    PH_RECONF = 3'd3,
    PH_FILL   = 3'd4
  } phase_e;

  localparam int N_UNITS = 3; // rename, ooo scheduler, load queue
endpackage

// File: rtl/msw_hyst.sv
module msw_hyst #(
  parameter int CNT_W   = 4,
  parameter int HOLD_W  = 8,
  parameter int OOO_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              cur_ooo,
  input  logic [CNT_W-1:0]  threads,
  input  logic [HOLD_W-1:0] hold,
  output logic              fire
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(OOO_MAX);

  logic              want_ooo;
  logic              mismatch;
  logic [HOLD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    want_ooo = (threads <= LIMIT);
    mismatch = (want_ooo != cur_ooo);
    fire     = armed && mismatch && (cnt_q >= hold);
    cnt_d    = cnt_q;
    if (!armed || !mismatch || fire) cnt_d = '0;
    else                             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8: counting is frozen and cleared while a switch is under way
  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (cnt_q == '0));
  // R2: a match of the current mode restarts the hold count
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !mismatch) |=> (cnt_q == '0));
endmodule

// File: rtl/msw_seq.sv
module msw_seq
  import msw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fire,
  input  logic   pipe_empty,
  input  logic   spill_done,
  input  logic   fill_done,
  output phase_e phase,
  output logic   spill_go,
  output logic   fill_go,
  output logic   reconf
);
  phase_e phase_q, phase_d;
  logic   spill_q, spill_d;
  logic   fill_q, fill_d;

  always_comb begin
    phase_d = phase_q;
    spill_d = 1'b0;
    fill_d  = 1'b0;
    unique case (phase_q)
      PH_RUN:    if (fire) phase_d = PH_DRAIN;
      PH_DRAIN:  if (pipe_empty) begin
                   phase_d = PH_SPILL;
                   spill_d = 1'b1;
                 end
      PH_SPILL:  if (spill_done) phase_d = PH_RECONF;
      PH_RECONF: begin
                   phase_d = PH_FILL;
                   fill_d  = 1'b1;
                 end
      PH_FILL:   if (fill_done) phase_d = PH_RUN;
      default:   phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      spill_q <= spill_d;
      fill_q  <= fill_d;
    end
  end

  assign phase    = phase_q;
  assign spill_go = spill_q;
  assign fill_go  = fill_q;
  assign reconf   = (phase_q == PH_RECONF);

  // R3: the drain phase holds until the pipeline reports empty
  a_r3_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DRAIN && !pipe_empty) |=> (phase_q == PH_DRAIN));
  // R4: the save start is a single-cycle pulse inside the save phase
  a_r4_spill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    spill_q |-> (phase_q == PH_SPILL) ##1 !spill_q);
  // R6: the load start comes only at the first cycle of the load phase
  a_r6_fill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q |-> (phase_q == PH_FILL && $past(phase_q) == PH_RECONF));
endmodule

// File: rtl/msw_mode.sv
module msw_mode
  import msw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reconf,
  output logic               ooo,
  output logic [N_UNITS-1:0] unit_en,
  output logic               rat_upd
);
  logic mode_q, mode_d;
  logic rat_q, rat_d;

  always_comb begin
    mode_d = reconf ? ~mode_q : mode_q;
    rat_d  = reconf && !mode_q;   // leaving in-order means entering out-of-order
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b1;
      rat_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rat_q  <= rat_d;
    end
  end

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic en_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= 1'b1;
      else if (reconf) en_q <= ~mode_q;
    end
    assign unit_en[u] = en_q;
  end

  assign ooo     = mode_q;
  assign rat_upd = rat_q;

  // R5: the mode only changes on the reconfigure step
  a_r5_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !reconf |=> $stable(mode_q));
endmodule

// File: rtl/mode_switch_ctrl.sv
module mode_switch_ctrl
  import msw_pkg::*;
#(
  parameter int MAX_THREADS = 8,
  parameter int OOO_MAX     = 2,
  parameter int HOLD_W      = 8,
  localparam int CNT_W      = $clog2(MAX_THREADS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  active_threads,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic              pipe_empty,
  input  logic              spill_done,
  input  logic              fill_done,
  output logic              drain_req,
  output logic              spill_start,
  output logic              fill_start,
  output logic              rat_update,
  output logic              rename_en,
  output logic              ooo_sched_en,
  output logic              ldq_en,
  output logic              mode_ooo,
  output logic              fetch_stall
);
  phase_e             phase;
  logic               fire;
  logic               reconf;
  logic [N_UNITS-1:0] unit_en;

  msw_hyst #(.CNT_W(CNT_W), .HOLD_W(HOLD_W), .OOO_MAX(OOO_MAX)) u_hyst (
    .clk(clk), .rst_n(rst_n), .armed(phase == PH_RUN), .cur_ooo(mode_ooo),
    .threads(active_threads), .hold(hold_cycles), .fire(fire)
  );

  msw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pipe_empty(pipe_empty),
    .spill_done(spill_done), .fill_done(fill_done), .phase(phase),
    .spill_go(spill_start), .fill_go(fill_start), .reconf(reconf)
  );

  msw_mode u_mode (
    .clk(clk), .rst_n(rst_n), .reconf(reconf), .ooo(mode_ooo),
    .unit_en(unit_en), .rat_upd(rat_update)
  );

  assign drain_req    = (phase == PH_DRAIN);
  assign fetch_stall  = (phase != PH_RUN);
  assign rename_en    = unit_en[0];
  assign ooo_sched_en = unit_en[1];
  assign ldq_en       = unit_en[2];

  // R7: the pipeline is never drained while fetch is still running
  a_r7_stall_cover: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req || spill_start || fill_start) |-> fetch_stall);
  // R6: map tables are rebuilt only when entering out-of-order mode
  a_r6_rat_ooo: assert property (@(posedge clk) disable iff (!rst_n)
    rat_update |-> (mode_ooo && fill_start));
  // R5: unit enables follow the mode
  a_r5_units: assert property (@(posedge clk) disable iff (!rst_n)
    (rename_en == mode_ooo) && (ooo_sched_en == mode_ooo) && (ldq_en == mode_ooo));
endmodule

// File: tb/mode_switch_ctrl_bench.sv
module mode_switch_ctrl_bench;
  localparam int CNT_W  = 4;
  localparam int HOLD_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CNT_W-1:0]  active_threads;
  logic [HOLD_W-1:0] hold_cycles;
  logic              pipe_empty, spill_done, fill_done;
  logic              drain_req, spill_start, fill_start, rat_update;
  logic              rename_en, ooo_sched_en, ldq_en, mode_ooo, fetch_stall;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model: 0 idle, 1 drain, 2 save, 3 reconfigure, 4 load
  int m_st;
  bit m_ooo;
  int m_cnt;
  bit m_sp, m_fl, m_rat;

  always #5 clk = ~clk;

  mode_switch_ctrl u_mode_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .active_threads(active_threads),
    .hold_cycles(hold_cycles), .pipe_empty(pipe_empty),
    .spill_done(spill_done), .fill_done(fill_done), .drain_req(drain_req),
    .spill_start(spill_start), .fill_start(fill_start),
    .rat_update(rat_update), .rename_en(rename_en),
    .ooo_sched_en(ooo_sched_en), .ldq_en(ldq_en), .mode_ooo(mode_ooo),
    .fetch_stall(fetch_stall)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R3 drain_req",    drain_req,    m_st == 1);
    chk("R4 spill_start",  spill_start,  m_sp);
    chk("R6 fill_start",   fill_start,   m_fl);
    chk("R6 rat_update",   rat_update,   m_rat);
    chk("R5 rename_en",    rename_en,    m_ooo);
    chk("R5 ooo_sched_en", ooo_sched_en, m_ooo);
    chk("R5 ldq_en",       ldq_en,       m_ooo);
    chk("R1 mode_ooo",     mode_ooo,     m_ooo);
    chk("R7 fetch_stall",  fetch_stall,  m_st != 0);
  endtask

  // Drive one cycle of inputs, advance the model over the next edge, compare after it.
  task automatic step(input int thr, input int hold, input bit pe, input bit sd, input bit fd);
    bit want;
    active_threads = CNT_W'(thr);
    hold_cycles    = HOLD_W'(hold);
    pipe_empty = pe; spill_done = sd; fill_done = fd;
    m_sp = 0; m_fl = 0; m_rat = 0;
    case (m_st)
      0: begin
        want = (thr <= 2);
        if (want != m_ooo) begin
          if (m_cnt >= hold) begin m_st = 1; m_cnt = 0; end
          else m_cnt++;
        end else m_cnt = 0;
      end
      1: if (pe) begin m_st = 2; m_sp = 1; end
      2: if (sd) m_st = 3;
      3: begin m_ooo = !m_ooo; m_st = 4; m_fl = 1; m_rat = m_ooo; end
      4: if (fd) begin m_st = 0; m_cnt = 0; end
      default: m_st = 0;
    endcase
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    rst_n = 1'b0;
    active_threads = '0; hold_cycles = '0;
    pipe_empty = 0; spill_done = 0; fill_done = 0;
    m_st = 0; m_ooo = 1; m_cnt = 0; m_sp = 0; m_fl = 0; m_rat = 0;
    @(negedge clk); @(negedge clk);
    // R10: reset state while reset is held
    chk("R10 mode in reset", mode_ooo, 1);
    chk("R10 enables in reset", {rename_en, ooo_sched_en, ldq_en}, 7);
    chk("R10 strobes in reset",
        {drain_req, spill_start, fill_start, rat_update, fetch_stall}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all(); // R10 right after release

    // R9: handshakes while idle do nothing
    step(1, 0, 1, 1, 1);
    step(2, 0, 1, 1, 1);
    chk("R9 idle handshakes ignored", fetch_stall, 0);

    // R2: request held for hold+1 edges, hold = 3
    step(5, 3, 0, 0, 0);
    step(5, 3, 0, 0, 0);
    step(5, 3, 0, 0, 0);
    chk("R2 no drain before hold expires", drain_req, 0);
    // R2: one matching edge restarts the count
    step(1, 3, 0, 0, 0);
    step(5, 3, 0, 0, 0);
    step(5, 3, 0, 0, 0);
    step(5, 3, 0, 0, 0);
    chk("R2 restart after matching edge", drain_req, 0);
    step(5, 3, 0, 0, 0);
    chk("R2 drain after hold+1 edges", drain_req, 1);

    // R8 / R9: thread count and out-of-phase handshakes during drain
    step(1, 3, 0, 1, 1);
    step(0, 0, 0, 1, 1);
    chk("R8 drain holds despite thread count", drain_req, 1);
    step(6, 3, 1, 0, 1);
    chk("R4 save pulse after drain", spill_start, 1);
    step(1, 0, 1, 0, 1);
    chk("R9 save phase ignores load done", fill_start, 0);
    step(1, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0);
    chk("R5 in-order enables off", {rename_en, ooo_sched_en, ldq_en}, 0);
    chk("R6 no rebuild entering in-order", rat_update, 0);
    chk("R6 load pulse", fill_start, 1);
    step(1, 0, 0, 0, 1);
    chk("R7 fetch released after load done", fetch_stall, 0);
    chk("R1 in-order mode", mode_ooo, 0);

    // back to out-of-order, hold = 0
    step(2, 0, 0, 0, 0);
    chk("R2 hold zero starts at once", drain_req, 1);
    step(2, 0, 1, 0, 0);
    step(2, 0, 0, 1, 0);
    step(2, 0, 0, 0, 0);
    chk("R6 rebuild entering out-of-order", rat_update, 1);
    chk("R5 enables on", {rename_en, ooo_sched_en, ldq_en}, 7);
    step(2, 0, 0, 0, 1);
    chk("R1 out-of-order mode", mode_ooo, 1);

    // boundary: exactly 2 and 3 threads
    step(2, 0, 0, 0, 0);
    chk("R1 two threads stay out-of-order", drain_req, 0);
    step(3, 0, 0, 0, 0);
    chk("R1 three threads request in-order", drain_req, 1);
    step(3, 0, 1, 0, 0);
    step(3, 0, 0, 1, 0);
    step(3, 0, 0, 0, 0);
    step(3, 0, 0, 0, 1);

    // random phase
    begin
      int thr = 1;
      int hold = 2;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 15) == 0) thr = $urandom_range(0, 8);
        if ($urandom_range(0, 63) == 0) hold = $urandom_range(0, 6);
        step(thr, hold, $urandom_range(0, 3) == 0,
             $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule